// File: doc/BRIEF.md
# Two-Wire Register Slave with Persistent Pointer

This block lets a host on a two-wire serial bus read and write a bank of 8-bit registers. The registers themselves live outside the block. It runs on a system clock that is much faster than the bus clock. Both bus lines pass through a resynchroniser, and the block finds clock edges, START and STOP by comparing consecutive samples. The only thing the block drives onto the bus is an output enable: when it is 1, the data line is pulled low.

The 7-bit slave address is made of two parts:
- the five upper bits, which are fixed;
- the two lower bits, which come from a three-level strap input that is decoded and latched only during reset.

A write transfer always starts with a pointer byte, which is kept across transfers. An optional second byte is written to the register that the pointer selects. A read transfer returns the register that the pointer currently selects.

The register file is reached over plain strobes that carry no back-pressure:
- a write strobe lasts one cycle and must be accepted in that cycle;
- a read strobe lasts one cycle, and the register file must present the selected register's value on the read data input during the following cycle.

Top module: `twowire_reg_slave`

## Requirements
- R1: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A START in any state begins a new address phase, even in the middle of a byte. A STOP in any state returns the slave to idle, and it then ignores everything until the next START.
- R2: After a START, the slave shifts in eight bits, MSB first: a 7-bit address, then a direction bit (0 = host writes, 1 = host reads). When the address equals the device address, the slave pulls the data line low during the 9th clock.
- R3: A byte whose address does not match gets no acknowledge. The slave then drives nothing and issues no strobes until the next START.
- R4: The device address is binary 01011 followed by two low bits. The strap code sets those low bits: code 00 (tied low) gives 10, code 01 (floating) gives 00, and code 10 (tied high) gives 01. Code 11 is treated as floating.
- R5: The strap is sampled only while reset is asserted. Changing it afterwards does not change the device address.
- R6: In a write transfer, the first data byte is acknowledged and stored in the pointer. It produces no write strobe.
- R7: In a write transfer, the second data byte is acknowledged. It produces one single-cycle write strobe, with the pointer value as the register address and that byte as the data.
- R8: In a write transfer, data bytes after the second are acknowledged but produce no strobe, and they leave the pointer unchanged.
- R9: In a read transfer, the slave issues one single-cycle read strobe with the pointer as the address. It then sends the returned byte MSB first, with the first bit already on the line before the first data clock.
- R10: The pointer resets to 00h and keeps its value across transfers. A read with no earlier pointer write addresses register 00h.
- R11: The slave changes its data-line drive only while the clock line is low. It releases the line after the 9th clock of each byte it acknowledges.
- R12: When the host does not acknowledge a read byte, the slave releases the data line and issues no further read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset; the strap is latched while this is low |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 2 | Address strap code: 00 tied low, 01 floating, 10 tied high |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register index for the write |
| wr_data | output | 8 | Byte to write |
| rd_req | output | 1 | One-cycle register read strobe |
| rd_addr | output | 8 | Register index for the read |
| rd_data | input | 8 | Register value, valid the cycle after rd_req |

## Verification
Two events fall on the same sampled clock fall:
- the acknowledge drive for the second data byte;
- the write strobe for that byte.

The bench writes sixteen pointer/data pairs. For each pair it checks two things: that the host sees the acknowledge during the 9th clock, and that exactly one strobe carries the pointer and data the bench expects. A second collision is a repeated START that arrives right after an acknowledged pointer byte, while the byte engine is waiting for more data bits. The bench follows that repeated START with a read and checks that the read strobe addresses the pointer that was just loaded. It also checks that the returned byte arrives intact.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RWAIT,
    ST_RLOAD,
    ST_RDATA,
    ST_RACK
  } tws_state_t;

  localparam logic [1:0] STRAP_LOW   = 2'b00;
  localparam logic [1:0] STRAP_FLOAT = 2'b01;
  localparam logic [1:0] STRAP_HIGH  = 2'b10;

  function automatic logic [1:0] strap_to_low_bits(input logic [1:0] code);
    case (code)
      STRAP_LOW:  return 2'b10;
      STRAP_HIGH: return 2'b01;
      default:    return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_raw,
  input  logic       sda_raw,
  output logic       scl_s,
  output logic       sda_s,
  output logic       scl_rise,
  output logic       scl_fall,
  output logic       start_ev,
  output logic       stop_ev
);
  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prev;

  assign raw = {sda_raw, scl_raw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= cur;
  end

  assign scl_s    = cur[0];
  assign sda_s    = cur[1];
  assign scl_rise = cur[0] & ~prev[0];
  assign scl_fall = ~cur[0] & prev[0];
  assign start_ev = cur[0] & prev[0] & prev[1] & ~cur[1];
  assign stop_ev  = cur[0] & prev[0] & ~prev[1] & cur[1];

endmodule

// File: rtl/tws_strap.sv
module tws_strap #(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  output logic [6:0] dev_addr
);
  import tws_pkg::*;

  logic [1:0] low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) low_q <= strap_to_low_bits(strap_i);
  end

  assign dev_addr = {ADDR_HI, low_q};

  a_r5_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(low_q));

endmodule

// File: rtl/tws_engine.sv
module tws_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [6:0]        dev_addr,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  import tws_pkg::*;

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  tws_state_t        state;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] ptr;
  logic [CW-1:0]     cnt;
  logic [1:0]        widx;
  logic              rw;
  logic              nak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      cnt      <= '0;
      widx     <= '0;
      rw       <= 1'b0;
      nak      <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[BYTE_W-1:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  widx   <= 2'd0;
                  state  <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                case (widx)
                  2'd0: begin
                    ptr  <= sh;
                    widx <= 2'd1;
                  end
                  2'd1: begin
                    wr_valid <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= sh;
                    widx     <= 2'd2;
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (rw) begin
                rd_req  <= 1'b1;
                rd_addr <= ptr;
                state   <= ST_RWAIT;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_RWAIT: state <= ST_RLOAD;
          ST_RLOAD: begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
            cnt    <= '0;
            state  <= ST_RDATA;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else if (cnt != '0) begin
                tx     <= {tx[BYTE_W-2:0], tx[BYTE_W-1]};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nak <= sda_s;
            end else if (scl_fall) begin
              if (nak) begin
                state <= ST_IDLE;
              end else begin
                rd_req  <= 1'b1;
                rd_addr <= ptr;
                state   <= ST_RWAIT;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r11_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r7_write_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r7_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_oe);

  a_r9_read_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_ev) |-> !sda_oe);

endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_i,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] dev_addr;

  tws_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tws_strap #(.ADDR_HI(ADDR_HI)) i_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .dev_addr(dev_addr)
  );

  tws_engine #(.BYTE_W(8)) i_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .dev_addr(dev_addr), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/test_twowire_reg_slave.sv
module test_twowire_reg_slave;
  localparam int HP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_oe, wr_valid, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic       sda_bus;
  logic [7:0] mem [256];

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, viol = 0;
  logic [7:0] last_wa, last_wd, last_ra;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  twowire_reg_slave i_twowire_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(posedge clk) begin
    if (wr_valid) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wd <= wr_data;
    end
    if (rd_req) begin
      rd_data <= mem[rd_addr];
      rd_cnt <= rd_cnt + 1; last_ra <= rd_addr;
    end
    if (rst_n && sda_oe != prev_oe && m_scl && prev_scl) viol <= viol + 1;
    prev_oe <= sda_oe; prev_scl <= m_scl;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half(); repeat (HP) @(negedge clk); endtask

  task automatic do_reset(input logic [1:0] s);
    strap = s; rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; half(); m_scl = 1'b1;
    repeat (HP / 2) @(negedge clk);
    ack = (sda_bus == 1'b0);
    repeat (HP / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit nak, output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      half(); m_scl = 1'b1;
      repeat (HP / 2) @(negedge clk);
      b = {b[6:0], sda_bus};
      repeat (HP / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = nak; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
  endtask

  task automatic set_ptr(input logic [6:0] dev, input logic [7:0] p, output bit a0, output bit a1);
    m_start(); send_byte({dev, 1'b0}, a0); send_byte(p, a1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] rb;
    int c0, r0, acks;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);
    mem[0] = 8'h3C;

    do_reset(2'b01);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0, "R11", "reset outputs idle", sda_oe, 0);

    // R2 R3 R4: address sweep under each strap code
    for (int s = 0; s < 3; s++) begin
      logic [6:0] exp_dev;
      exp_dev = {5'b01011, (s == 0) ? 2'b10 : (s == 1) ? 2'b00 : 2'b01};
      do_reset(2'(s));
      acks = 0;
      for (int a = 0; a < 128; a++) begin
        if (s != 1 && (a < 8'h28 || a > 8'h2F)) continue;
        c0 = wr_cnt; r0 = rd_cnt;
        m_start(); send_byte({7'(a), 1'b0}, a0);
        if (a0) begin send_byte(8'h00, a1); end
        else begin send_byte(8'h12, a1); send_byte(8'h34, a2); end
        m_stop();
        if (a0) acks++;
        if (7'(a) == exp_dev) chk(a0 == 1'b1, "R2", "ack on matching address", a0, 1);
        else begin
          chk(a0 == 1'b0 && a1 == 1'b0 && a2 == 1'b0, "R3", "no ack on mismatch", a0, 0);
          chk(wr_cnt == c0 && rd_cnt == r0, "R3", "no strobes on mismatch", wr_cnt - c0, 0);
        end
      end
      chk(acks == 1, "R4", "exactly one acked address per strap", acks, 1);
    end

    // R5: strap changes after reset are ignored
    do_reset(2'b10);
    strap = 2'b00;
    repeat (20) @(negedge clk);
    m_start(); send_byte({7'h2E, 1'b0}, a0); m_stop();
    chk(a0 == 1'b0, "R5", "new strap address not acked", a0, 0);
    m_start(); send_byte({7'h2D, 1'b0}, a0); m_stop();
    chk(a0 == 1'b1, "R5", "latched strap address still acked", a0, 1);

    // R10: pointer resets to 00h
    do_reset(2'b01);
    r0 = rd_cnt;
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb); m_stop();
    chk(rd_cnt == r0 + 1 && last_ra == 8'h00, "R10", "read after reset addresses 00h", last_ra, 0);
    chk(rb == 8'h3C, "R9", "read data of register 00h", rb, 8'h3C);

    // R7: write pairs; ack and strobe on the same byte
    for (int i = 0; i < 16; i++) begin
      logic [7:0] ra, va;
      ra = 8'(i * 16 + 3); va = 8'(i * 37 + 5);
      c0 = wr_cnt;
      set_ptr(7'h2C, ra, a0, a1); send_byte(va, a2); m_stop();
      chk(a0 && a1 && a2, "R7", "all bytes acked", {a0, a1, a2}, 7);
      chk(wr_cnt == c0 + 1 && last_wa == ra && last_wd == va, "R7", "write strobe addr/data",
          {last_wa, last_wd}, {ra, va});
    end

    // R6: pointer-only write sets pointer, no strobe
    c0 = wr_cnt; r0 = rd_cnt;
    set_ptr(7'h2C, 8'h77, a0, a1); m_stop();
    chk(a1 == 1'b1 && wr_cnt == c0, "R6", "pointer byte acked without strobe", wr_cnt - c0, 0);
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb); m_stop();
    chk(last_ra == 8'h77 && rb == 8'(8'h77 ^ 8'hA5), "R6", "read uses pointer 77h", {last_ra, rb}, {8'h77, 8'(8'h77 ^ 8'hA5)});

    // R9 R1: pointer write then repeated START and read
    for (int i = 0; i < 16; i++) begin
      logic [7:0] ra, va;
      ra = 8'(i * 16 + 3); va = 8'(i * 37 + 5);
      set_ptr(7'h2C, ra, a0, a1);
      m_start(); send_byte({7'h2C, 1'b1}, a2); recv_byte(1'b1, rb); m_stop();
      chk(a2 && last_ra == ra, "R1", "repeated START then read strobe", last_ra, ra);
      chk(rb == va, "R9", "read data MSB first", rb, va);
    end

    // R10: pointer persists across reads
    r0 = rd_cnt;
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb); m_stop();
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb); m_stop();
    chk(rd_cnt == r0 + 2 && last_ra == 8'hF3, "R10", "pointer persistent", last_ra, 8'hF3);

    // R8: bytes beyond the second
    c0 = wr_cnt;
    set_ptr(7'h2C, 8'h40, a0, a1); send_byte(8'h11, a1); send_byte(8'h22, a2); send_byte(8'h33, a3); m_stop();
    chk(a1 && a2 && a3, "R8", "extra bytes acked", {a1, a2, a3}, 7);
    chk(wr_cnt == c0 + 1 && last_wd == 8'h11, "R8", "only one strobe", wr_cnt - c0, 1);
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb); m_stop();
    chk(last_ra == 8'h40 && rb == 8'h11, "R8", "pointer unchanged by extras", {last_ra, rb}, {8'h40, 8'h11});

    // R1: STOP mid-byte, START mid-byte
    c0 = wr_cnt;
    m_start(); send_byte({7'h2C, 1'b0}, a0); send_bits(8'hF0, 4); m_stop();
    chk(wr_cnt == c0 && sda_oe == 1'b0, "R1", "STOP aborts byte", wr_cnt - c0, 0);
    m_start(); send_bits({7'h2C, 1'b0}, 3);
    set_ptr(7'h2C, 8'h05, a0, a1); send_byte(8'h99, a2); m_stop();
    chk(a0 && a2 && last_wa == 8'h05 && last_wd == 8'h99, "R1", "START restarts address phase",
        {last_wa, last_wd}, 16'h0599);

    // R12: NACK ends read
    r0 = rd_cnt;
    set_ptr(7'h2C, 8'h05, a0, a1);
    m_start(); send_byte({7'h2C, 1'b1}, a0); recv_byte(1'b1, rb);
    repeat (3 * HP) @(negedge clk);
    chk(sda_oe == 1'b0 && rd_cnt == r0 + 1, "R12", "released after NACK", rd_cnt - r0, 1);
    m_stop();

    chk(viol == 0, "R11", "drive changes with clock high", viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule